// File: doc/BRIEF.md
# Core Storage Cycle Timing Generator

This block sequences one destructive-read, write-back cycle of a coincident-current core store. A cycle lasts 120 time units. A unit counter runs from 0 to 119 and moves on only when the unit clock enable `tick_i` is high. Every control window is decoded from the unit count and is held low while the block is idle.

The windows overlap and are not evenly spaced. Each one is half-open, `[first, last)`, in units:

| Window | Active units |
|---|---|
| Data-register clear | 0 to 14 |
| Three read-driver gates | 0 to 35, 8 to 74 (X side), 15 to 74 (Y side) |
| Read-select pulses | 7 to 34 (X), 15 to 34 (Y) |
| Sense strobe | 14 to 29 |
| Both inhibit halves | 68 to 104 |
| Write-select phase | 70 to the end of the cycle |

The write-select phase therefore ends exactly when the next cycle begins. A phase index reports which of the eight 15-unit phases is current.

A controller raises `start_i` while the block is idle. The request is taken on the next enabled unit. A one-clock done pulse marks the end of each cycle. If start is still high at that point, the next cycle begins at unit 0 with no idle gap.

Top module: `core_cycle_timer`

## Requirements
- R1: While `rst_ni` is low, `busy_o` and `done_o` are 0, `unit_o` and `phase_o` are 0, and every window output is 0.
- R2: When idle, start is taken only on a clock edge where both `start_i` and `tick_i` are high. After that edge `busy_o` is 1 and `unit_o` is 0. A start while `tick_i` is low leaves the block idle.
- R3: While busy, `unit_o` rises by exactly one on each clock edge with `tick_i` high and is held on every other edge.
- R4: `phase_o` equals `unit_o` divided by 15, rounded down (0 to 7).
- R5: `reg_clr_o` is 1 for units 0 to 14.
- R6: `rd_gate_a_o` is 1 for units 0 to 35, `rd_gate_x_o` for units 8 to 74, and `rd_gate_y_o` for units 15 to 74.
- R7: `sel_rd_x_o` is 1 for units 7 to 34, and `sel_rd_y_o` for units 15 to 34.
- R8: `sense_stb_o` is 1 for units 14 to 29.
- R9: Both bits of `inhibit_o` are 1 for units 68 to 104.
- R10: `sel_wr_o` is 1 from unit 70 through unit 119.
- R11: The enabled edge that ends unit 119 sets `done_o` to 1 for exactly one clock.
  - If `start_i` is high at that edge, the block stays busy with `unit_o` at 0.
  - Otherwise the block returns to idle with `unit_o` at 0.
- R12: While idle, every window output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Unit clock enable |
| start_i | input | 1 | Cycle request |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock pulse when a cycle ends |
| unit_o | output | 7 | Current unit, 0 to 119 |
| phase_o | output | 3 | Current phase, 0 to 7 |
| reg_clr_o | output | 1 | Data-register clear window |
| rd_gate_a_o | output | 1 | Common read-driver gate |
| rd_gate_x_o | output | 1 | X-side read-driver gate |
| rd_gate_y_o | output | 1 | Y-side read-driver gate |
| sel_rd_x_o | output | 1 | X read-select pulse |
| sel_rd_y_o | output | 1 | Y read-select pulse |
| sense_stb_o | output | 1 | Sense-amplifier strobe |
| inhibit_o | output | 2 | Inhibit window, one bit for each half of the store |
| sel_wr_o | output | 1 | Write-select phase |

## Verification
The hardest behaviour to reach from the ports is the hand-off at the last unit. There, the done pulse, the return of the counter to 0 and the choice between going idle and starting again all occur on one enabled edge.

The stimulus covers both cases:
- It keeps start high across several cycles so that cycles run back to back.
- It drops start during the final unit of the last cycle so that the block returns to idle.

Two further cases are forced by blocking the unit enable:
- a stall in the middle of a cycle, which checks that every window holds;
- a start request with no enable, which must be ignored.

// File: rtl/core_cycle_pkg.sv
package core_cycle_pkg;
  localparam int NWIN = 10;
  // window order: clr, rd_a, rd_x, rd_y, sel_x, sel_y, strobe, inh_lo, inh_hi, sel_wr
  localparam int WIN_LO [NWIN] = '{0, 0, 8, 15, 7, 15, 14, 68, 68, 70};
  // HI >= cycle length means the window runs to the end of the cycle
  localparam int WIN_HI [NWIN] = '{15, 36, 75, 75, 35, 35, 30, 105, 105, 120};
endpackage

// File: rtl/cycle_unit_ctr.sv
module cycle_unit_ctr #(
  parameter int UNITS = 120,
  parameter int UW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [UW-1:0] unit_o
);
  localparam logic [UW-1:0] LAST = UW'(UNITS - 1);

  logic          busy_q, done_q;
  logic [UW-1:0] unit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      unit_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        if (!busy_q) begin
          busy_q <= start_i;
          unit_q <= '0;
        end else if (unit_q == LAST) begin
          done_q <= 1'b1;
          busy_q <= start_i;
          unit_q <= '0;
        end else begin
          unit_q <= unit_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign unit_o = unit_q;

  // R3
  unit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> $stable(unit_q));
  // R2
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !(start_i && tick_i)) |=> !busy_q);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && unit_q == LAST) |=> (done_q && unit_q == '0));
  // R11
  back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && unit_q == LAST && start_i) |=> busy_q);
  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/cycle_window.sv
module cycle_window #(
  parameter int LO    = 0,
  parameter int HI    = 1,
  parameter int UNITS = 120,
  parameter int UW    = 7
) (
  input  logic [UW-1:0] unit_i,
  input  logic          en_i,
  output logic          act_o
);
  generate
    if (HI >= UNITS) begin : g_to_end
      if (LO == 0) begin : g_all
        assign act_o = en_i;
      end else begin : g_ge
        assign act_o = en_i && (unit_i >= UW'(LO));
      end
    end else if (HI > LO) begin : g_span
      if (LO == 0) begin : g_lt
        assign act_o = en_i && (unit_i < UW'(HI));
      end else begin : g_both
        assign act_o = en_i && (unit_i >= UW'(LO)) && (unit_i < UW'(HI));
      end
    end else begin : g_wrap
      assign act_o = en_i && ((unit_i >= UW'(LO)) || (unit_i < UW'(HI)));
    end
  endgenerate
endmodule

// File: rtl/core_cycle_timer.sv
module core_cycle_timer
  import core_cycle_pkg::*;
#(
  parameter  int UNITS     = 120,
  parameter  int PHASE_LEN = 15,
  localparam int UW        = $clog2(UNITS),
  localparam int PW        = $clog2(UNITS / PHASE_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [UW-1:0] unit_o,
  output logic [PW-1:0] phase_o,
  output logic          reg_clr_o,
  output logic          rd_gate_a_o,
  output logic          rd_gate_x_o,
  output logic          rd_gate_y_o,
  output logic          sel_rd_x_o,
  output logic          sel_rd_y_o,
  output logic          sense_stb_o,
  output logic [1:0]    inhibit_o,
  output logic          sel_wr_o
);
  logic [UW-1:0]   unit;
  logic            busy;
  logic [NWIN-1:0] win;

  cycle_unit_ctr #(.UNITS(UNITS), .UW(UW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (start_i),
    .busy_o  (busy),
    .done_o  (done_o),
    .unit_o  (unit)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    cycle_window #(.LO(WIN_LO[i]), .HI(WIN_HI[i]), .UNITS(UNITS), .UW(UW)) u_win (
      .unit_i (unit),
      .en_i   (busy),
      .act_o  (win[i])
    );
  end

  assign busy_o      = busy;
  assign unit_o      = unit;
  assign phase_o     = PW'(unit / UW'(PHASE_LEN));
  assign reg_clr_o   = win[0];
  assign rd_gate_a_o = win[1];
  assign rd_gate_x_o = win[2];
  assign rd_gate_y_o = win[3];
  assign sel_rd_x_o  = win[4];
  assign sel_rd_y_o  = win[5];
  assign sense_stb_o = win[6];
  assign inhibit_o   = {win[8], win[7]};
  assign sel_wr_o    = win[9];

  // R4
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_o) |-> ((unit % UW'(PHASE_LEN)) == '0));
  // R8
  strobe_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_stb_o |-> (sel_rd_x_o && rd_gate_a_o && !sel_wr_o));
  // R10
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_o |-> !(sel_rd_x_o || sel_rd_y_o || reg_clr_o));
  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (win == '0));
  // R9
  inh_halves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o[0] == inhibit_o[1]);
endmodule

// File: tb/tb_core_cycle_timer.sv
module tb_core_cycle_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, stall = 1'b0;
  logic busy_o, done_o, reg_clr_o, rd_gate_a_o, rd_gate_x_o, rd_gate_y_o;
  logic sel_rd_x_o, sel_rd_y_o, sense_stb_o, sel_wr_o;
  logic [6:0] unit_o;
  logic [2:0] phase_o;
  logic [1:0] inhibit_o;

  int n_tests = 0, n_fail = 0, cyc = 0, div = 0;
  logic done_pend = 1'b0, fin = 1'b0;
  logic [19:0] q[$];  // {unit, phase, flags}

  always #2 clk = ~clk;

  core_cycle_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .busy_o(busy_o), .done_o(done_o), .unit_o(unit_o), .phase_o(phase_o),
    .reg_clr_o(reg_clr_o), .rd_gate_a_o(rd_gate_a_o), .rd_gate_x_o(rd_gate_x_o),
    .rd_gate_y_o(rd_gate_y_o), .sel_rd_x_o(sel_rd_x_o), .sel_rd_y_o(sel_rd_y_o),
    .sense_stb_o(sense_stb_o), .inhibit_o(inhibit_o), .sel_wr_o(sel_wr_o)
  );

  function automatic logic in_w(int u, int lo, int hi);
    return (u >= lo) && (u < hi);
  endfunction

  function automatic logic [9:0] exp_flags(int u);
    return {in_w(u,0,15), in_w(u,0,36), in_w(u,8,75), in_w(u,15,75), in_w(u,7,35),
            in_w(u,15,35), in_w(u,14,30), in_w(u,68,105), in_w(u,68,105), in_w(u,70,120)};
  endfunction

  function automatic string req_of(int b);
    case (b)
      9: return "R5";
      8, 7, 6: return "R6";
      5, 4: return "R7";
      3: return "R8";
      2, 1: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [9:0] act_flags();
    return {reg_clr_o, rd_gate_a_o, rd_gate_x_o, rd_gate_y_o, sel_rd_x_o, sel_rd_y_o,
            sense_stb_o, inhibit_o[0], inhibit_o[1], sel_wr_o};
  endfunction

  task automatic check(string req, logic ok, logic [19:0] act, logic [19:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // unit enable: one clock in three unless stalled
  always @(posedge clk) begin
    #1;
    div = (div == 2) ? 0 : div + 1;
    tick = (div == 0) && !stall;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      check("R11", done_o == done_pend, 20'(done_o), 20'(done_pend));
      done_pend = 1'b0;
      if (busy_o) begin
        if (q.size() == 0) begin
          check("R2", 1'b0, 20'(busy_o), 20'd0);
        end else begin
          logic [19:0] a, e;
          a = {unit_o, phase_o, act_flags()};
          e = q[0];
          if (a[19:13] != e[19:13]) check("R3", 1'b0, a, e);
          else if (a[12:10] != e[12:10]) check("R4", 1'b0, a, e);
          else begin
            string r = "R5";
            for (int b = 0; b < 10; b++) if (a[b] != e[b]) r = req_of(b);
            check(r, a[9:0] == e[9:0], a, e);
          end
          if (tick) begin
            if (e[19:13] == 7'd119) done_pend = 1'b1;
            void'(q.pop_front());
          end
        end
      end else begin
        check("R12", act_flags() == '0, 20'(act_flags()), 20'd0);
      end
    end
  end

  task automatic run_cycles(int n);
    for (int c = 0; c < n; c++)
      for (int u = 0; u < 120; u++)
        q.push_back({7'(u), 3'(u / 15), exp_flags(u)});
    @(posedge clk); #1;
    start = 1'b1;
    while (q.size() > 1) begin @(posedge clk); #1; end
    start = 1'b0;
    while (q.size() > 0 || busy_o) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  task automatic check_idle(string req);
    @(negedge clk);
    check(req, !busy_o && unit_o == 0 && phase_o == 0 && act_flags() == '0 && !done_o,
          {unit_o, phase_o, act_flags()}, 20'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", !busy_o && !done_o && unit_o == 0 && phase_o == 0 && act_flags() == '0,
          {unit_o, phase_o, act_flags()}, 20'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: start with enable blocked is ignored
    @(posedge clk); #1; stall = 1'b1;
    @(posedge clk); #1; start = 1'b1;
    repeat (4) @(posedge clk);
    #1; start = 1'b0;
    check_idle("R2");
    @(posedge clk); #1; stall = 1'b0;

    // single cycle, R5..R10 per unit, R11 back to idle
    run_cycles(1);
    check_idle("R11");

    // back-to-back cycles with a stall mid-way (R3)
    fork
      run_cycles(3);
      begin
        repeat (130) @(posedge clk);
        #1; stall = 1'b1;
        repeat (25) @(posedge clk);
        #1; stall = 1'b0;
      end
    join
    check_idle("R11");

    run_cycles(2);
    check_idle("R12");

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !fin) begin
      fin = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule